// File: doc/BRIEF.md
# Single-Entry Store Buffer

This block sits between the memory stage of one hardware thread and the DRAM port that thread owns. The block is clocked once per thread cycle. A store is accepted in the cycle it is presented and written into a one-place buffer. The block then sends the store to DRAM in the background while the thread moves on. Instructions that do not touch memory always pass at once. A load or store that arrives while the buffer still holds an unfinished store is held until DRAM reports completion. With a DRAM port that completes one cycle after the request, a store costs one cycle when the next instruction does not touch memory, and two cycles when it does.

Loads also go through the DRAM port. A load never takes its data from the buffered store. It waits until the store has drained and then reads DRAM, so a load always costs the same whatever address it uses. The thread keeps its operation on the request port until `op_ready` is high. Only one DRAM transaction is ever in flight.

Top module: `sb_store_buffer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `buf_full`, `dram_req` and `ld_valid` are 0.
- R2: A store (`op_kind` = 2'b10) presented while no DRAM transaction is open gets `op_ready` = 1 in the same cycle. In the next cycle `dram_req` = 1 for exactly one cycle, with `dram_we` = 1 and the store's address and data, and `buf_full` = 1.
- R3: When a store is followed by an instruction that does not touch memory, that instruction is accepted in the very next cycle, so the store costs one cycle.
- R4: A load (2'b01) or store presented while a DRAM transaction is open keeps `op_ready` = 0 until the cycle in which `dram_done` = 1, and is accepted in that cycle. With a one-cycle DRAM, a store followed by a memory operation therefore costs two cycles.
- R5: Kinds 2'b00 and 2'b11 do not touch memory. When `op_valid` = 1 they get `op_ready` = 1 in every state. They issue no DRAM request and do not change `buf_full`.
- R6: `buf_full` drops in the cycle after `dram_done`. If a new store is accepted in the done cycle, `buf_full` instead stays 1.
- R7: An accepted load issues `dram_req` with `dram_we` = 0 in the next cycle. `ld_valid` = 1 with `ld_data` = `dram_rdata` in the cycle `dram_done` answers it. Memory operations are held until then.
- R8: A load of the address held in the buffer is never served from the buffer. It is accepted only after the drain, and it returns the value the store wrote to DRAM.
- R9: N stores presented back to back are accepted every second cycle, starting at cycle c0. A following load is accepted at c0 + 2N, so the N stores take 2N cycles in total.
- R10: With `op_valid` = 0, `op_ready` = 0 and no DRAM request follows, whatever `op_kind` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Thread-cycle clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation is presented |
| op_kind | input | 2 | 00 non-memory, 01 load, 10 store, 11 non-memory |
| op_addr | input | AW | Load or store address |
| op_wdata | input | DW | Store data |
| op_ready | output | 1 | The presented operation is accepted this cycle |
| ld_valid | output | 1 | Load data is returned this cycle |
| ld_data | output | DW | Returned load data |
| buf_full | output | 1 | A store is held and not yet drained |
| dram_req | output | 1 | One-cycle DRAM request pulse |
| dram_we | output | 1 | The request is a write |
| dram_addr | output | AW | Request address |
| dram_wdata | output | DW | Write data |
| dram_done | input | 1 | The open DRAM request completes this cycle |
| dram_rdata | input | DW | Read data, valid with `dram_done` |

## Verification
The results fall due at different times:

- `op_ready` answers in the same cycle the operation is presented.
- `dram_req`, its address and data, and `buf_full` change one edge after acceptance.
- `ld_valid` follows `dram_done`. With the bench's one-cycle DRAM, that is two cycles after the load is accepted.

The bench drives its inputs at the falling edge and waits 1 ns. It compares every output against a behavioural model that has already advanced across the right number of edges. Operation costs are counted in steps until `op_ready`, so a one-cycle or two-cycle penalty shows up directly as a wait count.

// File: rtl/sb_pkg.sv
package sb_pkg;

  localparam logic [1:0] KIND_NONE  = 2'b00;
  localparam logic [1:0] KIND_LOAD  = 2'b01;
  localparam logic [1:0] KIND_STORE = 2'b10;
  localparam logic [1:0] KIND_SPARE = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_READ  = 2'd2
  } sb_state_e;

  // true for the two kinds that use the DRAM port
  function automatic logic kind_is_mem(logic [1:0] kind);
    return (kind == KIND_LOAD) || (kind == KIND_STORE);
  endfunction

  // the DRAM port can take a new operation this cycle
  function automatic logic slot_free(sb_state_e st, logic done);
    return (st == ST_IDLE) || done;
  endfunction

  // thread cycles a store costs, given whether the next op touches memory
  function automatic int unsigned store_cost(logic next_is_mem);
    return next_is_mem ? 2 : 1;
  endfunction

endpackage

// File: rtl/sb_classify.sv
module sb_classify
  import sb_pkg::*;
(
  input  logic       op_valid,
  input  logic [1:0] op_kind,
  output logic       want_ld,
  output logic       want_st,
  output logic       want_other
);

  assign want_ld    = op_valid && (op_kind == KIND_LOAD);
  assign want_st    = op_valid && (op_kind == KIND_STORE);
  assign want_other = op_valid && !kind_is_mem(op_kind);

endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import sb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic want_ld,
  input  logic want_st,
  input  logic want_other,
  input  logic dram_done,
  output logic op_ready,
  output logic take_st,
  output logic take_ld,
  output logic buf_full,
  output logic ld_valid
);

  sb_state_e st_q, st_d;
  logic      free_w;

  assign free_w   = slot_free(st_q, dram_done);
  assign take_st  = want_st & free_w;
  assign take_ld  = want_ld & free_w;
  assign op_ready = want_other | take_st | take_ld;

  always_comb begin
    st_d = st_q;
    if (take_st)                            st_d = ST_DRAIN;
    else if (take_ld)                       st_d = ST_READ;
    else if (st_q != ST_IDLE && dram_done)  st_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign buf_full = (st_q == ST_DRAIN);
  assign ld_valid = (st_q == ST_READ) && dram_done;

  // R6
  full_after_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_st |=> buf_full);

  // R6
  full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && dram_done && !take_st) |=> !buf_full);

  // R7
  load_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> !buf_full);

  // R5
  other_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (want_other && buf_full && !dram_done) |=> buf_full);

endmodule

// File: rtl/sb_entry.sv
module sb_entry #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_st,
  input  logic          take_ld,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_wdata,
  output logic          dram_req,
  output logic          dram_we,
  output logic [AW-1:0] dram_addr,
  output logic [DW-1:0] dram_wdata
);

  logic take_any;
  assign take_any = take_st | take_ld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dram_req   <= 1'b0;
      dram_we    <= 1'b0;
      dram_addr  <= '0;
      dram_wdata <= '0;
    end else begin
      dram_req <= take_any;
      if (take_any) begin
        dram_we    <= take_st;
        dram_addr  <= op_addr;
        dram_wdata <= op_wdata;
      end
    end
  end

  // R2
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dram_req |=> !dram_req);

  // R2
  req_follows_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_st |=> (dram_req && dram_we));

  // R7
  req_follows_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_ld |=> (dram_req && !dram_we));

endmodule

// File: rtl/sb_store_buffer.sv
module sb_store_buffer
  import sb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [1:0]    op_kind,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_wdata,
  output logic          op_ready,
  output logic          ld_valid,
  output logic [DW-1:0] ld_data,
  output logic          buf_full,
  output logic          dram_req,
  output logic          dram_we,
  output logic [AW-1:0] dram_addr,
  output logic [DW-1:0] dram_wdata,
  input  logic          dram_done,
  input  logic [DW-1:0] dram_rdata
);

  logic want_ld, want_st, want_other;
  logic take_st, take_ld;

  sb_classify u_classify (
    .op_valid   (op_valid),
    .op_kind    (op_kind),
    .want_ld    (want_ld),
    .want_st    (want_st),
    .want_other (want_other)
  );

  sb_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .want_ld    (want_ld),
    .want_st    (want_st),
    .want_other (want_other),
    .dram_done  (dram_done),
    .op_ready   (op_ready),
    .take_st    (take_st),
    .take_ld    (take_ld),
    .buf_full   (buf_full),
    .ld_valid   (ld_valid)
  );

  sb_entry #(.AW(AW), .DW(DW)) u_entry (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_st    (take_st),
    .take_ld    (take_ld),
    .op_addr    (op_addr),
    .op_wdata   (op_wdata),
    .dram_req   (dram_req),
    .dram_we    (dram_we),
    .dram_addr  (dram_addr),
    .dram_wdata (dram_wdata)
  );

  assign ld_data = dram_rdata;

  // R4
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && !dram_done && op_valid && kind_is_mem(op_kind)) |-> !op_ready);

  // R5
  other_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !kind_is_mem(op_kind)) |-> op_ready);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> (!op_ready ##1 !dram_req));

endmodule

// File: tb/sb_store_buffer_bench.sv
module sb_store_buffer_bench;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          op_valid;
  logic [1:0]    op_kind;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_wdata;
  logic          op_ready, ld_valid, buf_full;
  logic [DW-1:0] ld_data;
  logic          dram_req, dram_we;
  logic [AW-1:0] dram_addr;
  logic [DW-1:0] dram_wdata;
  logic          dram_done;
  logic [DW-1:0] dram_rdata;

  always #10 clk = ~clk;

  sb_store_buffer #(.AW(AW), .DW(DW)) u_sb_store_buffer (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_addr(op_addr), .op_wdata(op_wdata), .op_ready(op_ready),
    .ld_valid(ld_valid), .ld_data(ld_data), .buf_full(buf_full),
    .dram_req(dram_req), .dram_we(dram_we), .dram_addr(dram_addr),
    .dram_wdata(dram_wdata), .dram_done(dram_done), .dram_rdata(dram_rdata)
  );

  // one-cycle DRAM responder
  logic [DW-1:0] dmem [0:255];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dram_done  <= 1'b0;
      dram_rdata <= '0;
      for (int i = 0; i < 256; i++) dmem[i] <= '0;
    end else begin
      dram_done <= dram_req;
      if (dram_req && dram_we) dmem[dram_addr[7:0]] <= dram_wdata;
      dram_rdata <= (dram_req && !dram_we) ? dmem[dram_addr[7:0]] : 32'hDEAD_BEEF;
    end
  end

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model state
  int            m_busy;   // 0 idle, 1 draining store, 2 waiting for load
  bit            m_req, m_we;
  logic [AW-1:0] m_addr, m_ld_addr;
  logic [DW-1:0] m_wdata;
  logic [DW-1:0] gold [0:255];

  task automatic chk(string tag, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [1:0] k, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, output bit acc);
    bit mem, can, exp_ready, exp_ldv;
    @(negedge clk);
    op_valid = v; op_kind = k; op_addr = a; op_wdata = d;
    #1;
    mem       = v && (k == 2'b01 || k == 2'b10);
    can       = (m_busy == 0) || dram_done;
    exp_ready = v && (!mem || can);
    exp_ldv   = (m_busy == 2) && dram_done;
    chk(v ? "R4 R5" : "R10", "op_ready", op_ready, exp_ready);
    chk("R6", "buf_full", buf_full, m_busy == 1);
    chk("R2", "dram_req", dram_req, m_req);
    if (m_req) begin
      chk("R2", "dram_we", dram_we, m_we);
      chk("R2", "dram_addr", dram_addr, m_addr);
      if (m_we) chk("R2", "dram_wdata", dram_wdata, m_wdata);
    end
    chk("R7", "ld_valid", ld_valid, exp_ldv);
    if (exp_ldv) chk("R8", "ld_data", ld_data, gold[m_ld_addr[7:0]]);
    if (mem && can) begin
      if (k == 2'b10) begin
        m_busy = 1;
        gold[a[7:0]] = d;
      end else begin
        m_busy = 2;
        m_ld_addr = a;
      end
      m_req = 1; m_we = (k == 2'b10); m_addr = a; m_wdata = d;
    end else begin
      m_req = 0;
      if (dram_done) m_busy = 0;
    end
    acc = exp_ready;
  endtask

  task automatic issue(input logic [1:0] k, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, output int waits);
    bit acc;
    waits = 0;
    do begin
      step(1'b1, k, a, d, acc);
      waits++;
    end while (!acc && waits < 20);
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) step(1'b0, 2'b10, 16'h00FF, 32'h0, acc);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int w, sum;
    bit acc;
    for (int i = 0; i < 256; i++) gold[i] = '0;
    m_busy = 0; m_req = 0; m_we = 0; m_addr = '0; m_ld_addr = '0; m_wdata = '0;
    rst_n = 1'b0; op_valid = 1'b0; op_kind = 2'b00; op_addr = '0; op_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1", "buf_full in reset", buf_full, 0);
    chk("R1", "dram_req in reset", dram_req, 0);
    chk("R1", "ld_valid in reset", ld_valid, 0);
    rst_n = 1'b1;
    idle(1);

    // R2 R3: store then a non-memory op
    issue(2'b10, 16'h0010, 32'h1111_0001, w);
    chk("R2", "store wait on empty buffer", w, 1);
    issue(2'b00, 16'h0000, 32'h0, w);
    chk("R3", "alu after store wait", w, 1);
    idle(3);

    // R4 R6: store then store
    issue(2'b10, 16'h0020, 32'h2222_0002, w);
    issue(2'b10, 16'h0021, 32'h2222_0003, w);
    chk("R4", "store after store wait", w, 2);
    // R8: load of the buffered address
    issue(2'b01, 16'h0021, 32'h0, w);
    chk("R8", "load of buffered address wait", w, 2);
    // R7: store right after a load is held
    issue(2'b10, 16'h0030, 32'h3333_0004, w);
    chk("R7", "store after load wait", w, 2);
    // R5: spare kind while full
    issue(2'b11, 16'h0000, 32'h0, w);
    chk("R5", "spare kind while full wait", w, 1);
    idle(3);

    // R7 R5: load, alu, then store
    issue(2'b01, 16'h0010, 32'h0, w);
    chk("R7", "load on idle port wait", w, 1);
    issue(2'b00, 16'h0000, 32'h0, w);
    chk("R5", "alu during load wait", w, 1);
    issue(2'b10, 16'h0040, 32'h4444_0005, w);
    chk("R4", "store in load done cycle wait", w, 1);
    idle(3);

    // R9: burst of four stores then a load
    sum = 0;
    for (int n = 0; n < 4; n++) begin
      issue(2'b10, 16'h0050 + 16'(n), 32'h5500_0000 + 32'(n), w);
      sum += w;
    end
    chk("R9", "burst store waits", sum, 7);
    issue(2'b01, 16'h0053, 32'h0, w);
    chk("R9", "load after burst wait", w, 2);
    idle(3);

    // R10: valid low with a store kind
    step(1'b0, 2'b10, 16'h0060, 32'h6666_0006, acc);
    chk("R10", "ready with valid low", acc, 0);
    idle(2);
    chk("R10", "buf_full after invalid store", buf_full, 0);
    issue(2'b01, 16'h0060, 32'h0, w);
    idle(3);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule